// File: doc/BRIEF.md
# Filtered Multi-Line Change Detector

This block watches a bus of asynchronous digital input lines and emits a one-cycle event pulse whenever one of the lines makes a transition that software has enabled. Each line has its own rising-edge enable and falling-edge enable, so a line can report rises, falls, both or neither. The event pulse can clock other sampling logic directly. It also sets a sticky interrupt flag that stays set until it is cleared by a write-one pulse.

Every line first passes through a synchroniser. Each line can optionally be glitch-filtered. A filtered line's new value is accepted only on a filter tick, which is a one-cycle enable marking the edges of a slower filter clock. The value is accepted only if the line held steady for the whole period since the previous tick. If any filtered line moved during that period, the bus is treated as unsettled, and all pending filtered changes wait for the next tick. The accepted line values are brought out so that the logic receiving the event can read them. A line whose value nobody samples can still be enabled only to fire events, for example a slow square wave that forces a periodic update.

Top module: `line_change_detector`

## Requirements
- R1: After reset, event_o, irq_o and every bit of lines_o are 0.
- R2: On a line with filtering off and its rise enable set, a 0-to-1 change on pins_i makes lines_o take the new value and event_o go high for exactly one cycle, on the third rising clock edge after the change (two synchroniser stages plus one register).
- R3: On a line with filtering off and its fall enable set, a 1-to-0 change produces the same one-cycle event with the same latency.
- R4: A change on a line whose matching enable is clear still updates lines_o but leaves event_o low.
- R5: On a filtered line, lines_o changes only in the cycle after a cycle with fclk_tick_i high. A change is accepted at a tick only if the line stayed constant over the whole period since the previous tick, including the tick cycle itself. A tick that falls in the period in which the line changed does not accept it.
- R6: If any filtered line changed during a filter period, no filtered line is accepted at the tick that closes that period. A line that was itself stable is held back to the next quiet tick.
- R7: A pulse on a filtered line that returns to its old value before the next tick leaves lines_o unchanged and raises no event.
- R8: irq_o goes high in the cycle after event_o. It stays high until irq_clr_i is sampled high in a cycle in which event_o is low. A new event wins over a clear given in the same cycle.
- R9: Unfiltered lines are not delayed by activity on filtered lines. Several enabled edges in the same cycle give a single one-cycle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | W | Asynchronous input lines |
| rise_en_i | input | W | Per-line enable for 0-to-1 events |
| fall_en_i | input | W | Per-line enable for 1-to-0 events |
| filt_en_i | input | W | Per-line glitch-filter enable |
| fclk_tick_i | input | 1 | One-cycle filter clock edge marker |
| irq_clr_i | input | 1 | Write-one clear for the interrupt flag |
| event_o | output | 1 | One-cycle change-detection event |
| lines_o | output | W | Accepted (synchronised, filtered) line values |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The hardest case to reach is the bus-wide hold. A filtered line must sit fully stable through a period that is still rejected, because a different line moved inside that same period. The stimulus first changes one filtered line and closes that period with a tick, so the line is stable from then on. It then toggles a second filtered line between that tick and the next. At the second tick the first line must still show its old value. Only at a third tick, after a quiet period, are both lines accepted, with a single event.

// File: rtl/line_change_detector.sv
module line_change_detector #(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] filt_en_i,
  input  logic         fclk_tick_i,
  input  logic         irq_clr_i,
  output logic         event_o,
  output logic [W-1:0] lines_o,
  output logic         irq_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [W-1:0] sync_q [SYNC_STAGES];
  logic [W-1:0] prev_q, dirty_q, acc_q;
  logic         event_q, irq_q;

  logic [W-1:0] s, moved, window, differs, release_m, take, went_up, went_dn;
  logic         bus_busy, hit;

  assign s         = sync_q[LAST];
  assign moved     = s ^ prev_q;
  assign window    = (dirty_q | moved) & filt_en_i;
  assign bus_busy  = |window;
  assign differs   = s ^ acc_q;
  assign release_m = filt_en_i & differs & ~window & {W{fclk_tick_i & ~bus_busy}};
  assign take      = (~filt_en_i & differs) | release_m;
  assign went_up   = take & s;
  assign went_dn   = take & ~s;
  assign hit       = |((went_up & rise_en_i) | (went_dn & fall_en_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      prev_q  <= '0;
      dirty_q <= '0;
      acc_q   <= '0;
      event_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      sync_q[0] <= pins_i;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      prev_q  <= s;
      dirty_q <= fclk_tick_i ? '0 : window;
      acc_q   <= (acc_q & ~take) | (s & take);
      event_q <= hit;
      irq_q   <= event_q | (irq_q & ~irq_clr_i);
    end
  end

  assign event_o = event_q;
  assign lines_o = acc_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/line_change_detector_chk.sv
module line_change_detector_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] filt_en_i,
  input logic         fclk_tick_i,
  input logic         irq_clr_i,
  input logic         event_o,
  input logic [W-1:0] lines_o,
  input logic         irq_o
);
  // R8
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |=> irq_o);
  // R8
  irq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_clr_i |=> irq_o);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && irq_clr_i && !event_o |=> !irq_o);
  // R5
  filt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fclk_tick_i |=> ((lines_o ^ $past(lines_o)) & $past(filt_en_i)) == '0);
  // R4
  event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> lines_o != $past(lines_o));
endmodule

bind line_change_detector line_change_detector_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en_i(filt_en_i), .fclk_tick_i(fclk_tick_i),
  .irq_clr_i(irq_clr_i), .event_o(event_o), .lines_o(lines_o), .irq_o(irq_o)
);

// File: tb/test_line_change_detector.sv
module test_line_change_detector;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] pins = '0, rise = '0, fall = '0, filt = '0;
  logic tick = 0, clr = 0;
  logic ev, irq;
  logic [W-1:0] lines;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  line_change_detector #(.W(W)) i_line_change_detector (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .rise_en_i(rise), .fall_en_i(fall),
    .filt_en_i(filt), .fclk_tick_i(tick), .irq_clr_i(clr),
    .event_o(ev), .lines_o(lines), .irq_o(irq));

  task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick;
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic settle;
    filt = '0; rise = '0; fall = '0; pins = '0;
    cyc(6);
    clr = 1; cyc(1); clr = 0; cyc(1);
  endtask

  task automatic t_reset;
    chk(ev, 0, "R1 event");
    chk(lines, 0, "R1 lines");
    chk(irq, 0, "R1 irq");
  endtask

  task automatic t_rise_fall;
    rise = 8'h01; fall = 8'h02;
    pins = 8'h03; cyc(2);
    chk(ev, 0, "R2 event not early");
    cyc(1);
    chk(ev, 1, "R2 event on third edge");
    chk(lines, 8'h03, "R2 lines updated");
    cyc(1);
    chk(ev, 0, "R2 event one cycle");
    pins = 8'h01; cyc(3);
    chk(ev, 1, "R3 falling event");
    chk(lines, 8'h01, "R3 lines");
    cyc(1);
    chk(ev, 0, "R3 one cycle");
    settle;
  endtask

  task automatic t_disabled;
    rise = 8'h0E; fall = 8'h00;
    pins = 8'h01; cyc(3);
    chk(ev, 0, "R4 rise disabled no event");
    chk(lines, 8'h01, "R4 lines follow");
    pins = 8'h00; rise = 8'h01; cyc(3);
    chk(ev, 0, "R4 fall disabled no event");
    chk(lines, 8'h00, "R4 lines follow fall");
    settle;
  endtask

  task automatic t_filter;
    filt = 8'h01; rise = 8'h01;
    pins = 8'h01; cyc(5);
    pulse_tick;
    chk(ev, 0, "R5 changing period rejected");
    chk(lines, 8'h00, "R5 lines held");
    cyc(5);
    chk(lines, 8'h00, "R5 no change between ticks");
    pulse_tick;
    chk(ev, 1, "R5 accepted at quiet tick");
    chk(lines, 8'h01, "R5 lines accepted");
    cyc(1);
    chk(ev, 0, "R5 one cycle");
    filt = '0; settle;
  endtask

  task automatic t_bus_hold;
    filt = 8'h03; rise = 8'h03;
    pins = 8'h01; cyc(5);
    pulse_tick;
    chk(lines, 8'h00, "R6 first period rejected");
    cyc(2);
    pins = 8'h03; cyc(5);
    pulse_tick;
    chk(ev, 0, "R6 held by other line");
    chk(lines, 8'h00, "R6 stable line held back");
    cyc(3);
    pulse_tick;
    chk(ev, 1, "R6 released together");
    chk(lines, 8'h03, "R6 both accepted");
    settle;
  endtask

  task automatic t_glitch;
    filt = 8'h04; rise = 8'h04; fall = 8'h04;
    pulse_tick; cyc(2);
    pins = 8'h04; cyc(2); pins = 8'h00; cyc(5);
    pulse_tick;
    chk(ev, 0, "R7 glitch tick1 no event");
    cyc(4);
    pulse_tick;
    chk(ev, 0, "R7 glitch tick2 no event");
    chk(lines, 8'h00, "R7 lines unchanged");
    settle;
  endtask

  task automatic t_irq;
    rise = 8'h01;
    pins = 8'h01; cyc(3);
    chk(ev, 1, "R8 event");
    chk(irq, 0, "R8 irq not yet");
    cyc(1);
    chk(irq, 1, "R8 irq set");
    cyc(4);
    chk(irq, 1, "R8 irq sticky");
    clr = 1; cyc(1); clr = 0;
    chk(irq, 0, "R8 irq cleared");
    clr = 1; pins = 8'h00; rise = 8'h00; fall = 8'h01; cyc(3);
    chk(ev, 1, "R8 event under clear");
    cyc(1);
    chk(irq, 1, "R8 set beats clear");
    cyc(1);
    chk(irq, 0, "R8 clear after event");
    clr = 0;
    settle;
  endtask

  task automatic t_mixed;
    filt = 8'h01; rise = 8'h0C;
    pins = 8'h01; cyc(1); pins = 8'h00; cyc(1); pins = 8'h05; cyc(3);
    chk(ev, 1, "R9 unfiltered not delayed");
    chk(lines & 8'h04, 8'h04, "R9 unfiltered line value");
    cyc(1);
    pins = 8'h0D; cyc(3);
    chk(ev, 1, "R9 single edge event");
    cyc(1);
    chk(ev, 0, "R9 event one cycle");
    pins = 8'h01; cyc(3);
    pins = 8'h0D; cyc(3);
    chk(ev, 1, "R9 two edges one event");
    chk(lines & 8'h0C, 8'h0C, "R9 both lines");
    cyc(1);
    chk(ev, 0, "R9 merged pulse one cycle");
    settle;
  endtask

  initial begin
    cyc(4);
    t_reset;
    rst_n = 1;
    cyc(2);
    t_reset;
    t_rise_fall;
    t_disabled;
    t_filter;
    t_bus_hold;
    t_glitch;
    t_irq;
    t_mixed;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule